// File: doc/BRIEF.md
# Periodic Conversion Scheduler

This block paces the temperature conversions of a thermal monitor. A free-running tick input advances an internal counter. Once per period the block pulses a start request toward an external converter and powers it for a bounded conversion window. A result returned inside that window is held as pending. It is copied into the readable temperature register as soon as no bus transaction is in progress. Each copy raises a one-cycle sample strobe for the downstream event logic.

Completing any bus access restarts the period and launches a fresh conversion. While a transaction is in progress the pending result waits, so a host reading mid-conversion sees the older value. If the wait outlasts the idle gap and the next conversion begins, the waiting result is dropped. In shutdown the block stops counting and converting, and the last committed value stays readable. Leaving shutdown, and leaving reset with shutdown low, launches a conversion at once. Period and conversion lengths are parameters counted in ticks.

Top module: `conv_sched`

## Requirements
- R1: After reset `temp_o` is 0, `temp_valid_o` is 0 and `sample_o` is 0.
- R2: When `shutdown_i` is low in a cycle that follows reset or a cycle with `shutdown_i` high, `conv_start_o` is 1 in the next cycle and `conv_pwr_o` rises with it.
- R3: With no bus access and no shutdown, `conv_start_o` pulses when PERIOD_TICKS ticks have been counted since the previous start.
- R4: `conv_pwr_o` stays high from a start until a `conv_done_i` strobe is accepted or CONV_TICKS ticks have been counted. A `conv_done_i` strobe while `conv_pwr_o` is low is ignored.
- R5: An accepted result is copied to `temp_o` one cycle after acceptance when `bus_busy_i` is low. In that same cycle `sample_o` is 1 for one cycle and `temp_valid_o` becomes 1.
- R6: While `bus_busy_i` is high no result is committed and `temp_o` does not change. A pending result is committed in the cycle after `bus_busy_i` is seen low.
- R7: If a new conversion starts while `bus_busy_i` is high and a result is pending, that result is discarded and never reaches `temp_o`.
- R8: A `bus_done_i` pulse outside shutdown resets the period counter and makes `conv_start_o` 1 in the next cycle.
- R9: While `shutdown_i` is high, `conv_start_o` and `conv_pwr_o` are 0 from the next cycle on. `bus_done_i` and `conv_done_i` have no effect in this state, and `temp_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase tick, one count per cycle it is high |
| shutdown_i | input | 1 | Shutdown request, level |
| bus_busy_i | input | 1 | High while a bus transaction is in progress |
| bus_done_i | input | 1 | One-cycle pulse when a bus read or write completes |
| conv_start_o | output | 1 | One-cycle conversion start request |
| conv_pwr_o | output | 1 | Converter power enable |
| conv_data_i | input | DATA_W | Converter result |
| conv_done_i | input | 1 | Converter result strobe |
| temp_o | output | DATA_W | Committed temperature value |
| temp_valid_o | output | 1 | A result has been committed since reset |
| sample_o | output | 1 | One-cycle pulse on each commit |

## Verification
The hardest case to reach from the ports is a lost result. A conversion must finish, the bus must then stay busy for the remaining gap, and the period must roll over into a new start before the bus frees. The directed part of the stimulus freezes the tick input while the result is captured under a busy bus. It then releases the tick with the bus still held until the period wraps. After that it frees the bus and confirms that the old value and a silent sample strobe remain. Random traffic with long busy runs and slow ticks then drives the same race at many phases against a bench reference model.

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int PERIOD_TICKS = 100,
  parameter int CONV_TICKS   = 60,
  parameter int DATA_W       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              shutdown_i,
  input  logic              bus_busy_i,
  input  logic              bus_done_i,
  output logic              conv_start_o,
  output logic              conv_pwr_o,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              conv_done_i,
  output logic [DATA_W-1:0] temp_o,
  output logic              temp_valid_o,
  output logic              sample_o
);

  localparam int CW = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(PERIOD_TICKS - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_TICKS - 1);

  logic [CW-1:0]     cnt;
  logic              conv_busy;
  logic              shut_q;
  logic              pend;
  logic [DATA_W-1:0] pend_data;

  wire period_end   = tick_i && (cnt == LAST_TICK);
  wire start        = !shutdown_i && (shut_q || bus_done_i || period_end);
  wire accept       = conv_busy && conv_done_i && !start && !shutdown_i;
  wire commit       = pend && !bus_busy_i;
  wire conv_timeout = tick_i && (cnt == CONV_LAST);

  assign conv_pwr_o = conv_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shut_q       <= 1'b1;
      conv_start_o <= 1'b0;
      sample_o     <= 1'b0;
      temp_o       <= '0;
      temp_valid_o <= 1'b0;
      pend         <= 1'b0;
      pend_data    <= '0;
      conv_busy    <= 1'b0;
      cnt          <= '0;
    end else begin
      shut_q       <= shutdown_i;
      conv_start_o <= start;
      sample_o     <= commit;
      if (commit) begin
        temp_o       <= pend_data;
        temp_valid_o <= 1'b1;
      end
      if (accept) begin
        pend      <= 1'b1;
        pend_data <= conv_data_i;
      end else if (commit || start) begin
        pend <= 1'b0;
      end
      if (shutdown_i)                   conv_busy <= 1'b0;
      else if (start)                   conv_busy <= 1'b1;
      else if (accept || conv_timeout)  conv_busy <= 1'b0;
      if (shutdown_i || start)          cnt <= '0;
      else if (tick_i)                  cnt <= cnt + 1'b1;
    end
  end

  AST_START_POWERS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> conv_pwr_o); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_TICK); // R3
  AST_SAMPLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> temp_valid_o); // R5
  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_o |-> $stable(temp_o)); // R6
  AST_BUSY_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy_i |=> !sample_o); // R6
  AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (!conv_start_o && !conv_pwr_o)); // R9

endmodule

// File: tb/conv_sched_test.sv
module conv_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 8;
  localparam int CNV = 5;
  localparam int DW  = 13;

  logic clk = 0, rst_n = 0;
  logic tick = 1, shut = 1, busy = 0, bdone = 0, cdone = 0;
  logic [DW-1:0] cdata = '0;
  logic start_o, pwr_o, valid_o, sample_o;
  logic [DW-1:0] temp_o;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_sched #(.PERIOD_TICKS(PER), .CONV_TICKS(CNV), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .shutdown_i(shut),
    .bus_busy_i(busy), .bus_done_i(bdone), .conv_start_o(start_o),
    .conv_pwr_o(pwr_o), .conv_data_i(cdata), .conv_done_i(cdone),
    .temp_o(temp_o), .temp_valid_o(valid_o), .sample_o(sample_o));

  // reference model built from the requirements
  int m_cnt; logic m_shq, m_pwr, m_start, m_sample, m_val, m_pend;
  logic [DW-1:0] m_temp, m_pdat;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_shq <= 1; m_pwr <= 0; m_start <= 0; m_sample <= 0;
      m_val <= 0; m_pend <= 0; m_temp <= '0; m_pdat <= '0;
    end else begin : mdl
      logic st, acc, cm;
      st  = !shut && (m_shq || bdone || (tick && m_cnt == PER-1));
      acc = m_pwr && cdone && !st && !shut;
      cm  = m_pend && !busy;
      m_shq <= shut; m_start <= st; m_sample <= cm;
      if (cm) begin m_temp <= m_pdat; m_val <= 1; end
      if (acc) begin m_pend <= 1; m_pdat <= cdata; end
      else if (cm || st) m_pend <= 0;
      if (shut || st) m_cnt <= 0; else if (tick) m_cnt <= m_cnt + 1;
      if (shut) m_pwr <= 0;
      else if (st) m_pwr <= 1;
      else if (acc || (tick && m_cnt == CNV-1)) m_pwr <= 0;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    step(); step();
    chk("R1 temp", temp_o, 0); chk("R1 valid", valid_o, 0); chk("R1 sample", sample_o, 0);
    rst_n = 1; step();
    chk("R9 no start in shutdown", start_o, 0);
    shut = 0; step();
    chk("R2 start on leaving shutdown", start_o, 1); chk("R2 power", pwr_o, 1);
    cdone = 1; cdata = 13'h0155; step(); cdone = 0; step();
    chk("R5 sample", sample_o, 1); chk("R5 temp", temp_o, 13'h0155); chk("R5 valid", valid_o, 1);
    for (int i = 0; i < 5; i++) begin step(); chk("R3 no early start", start_o, 0); end
    step(); chk("R3 period start", start_o, 1);
    for (int i = 0; i < 4; i++) begin step(); chk("R4 power held", pwr_o, 1); end
    step(); chk("R4 power timeout", pwr_o, 0);
    cdone = 1; cdata = 13'h0AAA; step(); cdone = 0; step();
    chk("R4 late done ignored", temp_o, 13'h0155); chk("R4 no sample", sample_o, 0);
    tick = 0; bdone = 1; step(); bdone = 0;
    chk("R8 start on bus access", start_o, 1);
    cdone = 1; cdata = 13'h1234; busy = 1; step(); cdone = 0;
    step(); step();
    chk("R6 deferred temp", temp_o, 13'h0155); chk("R6 deferred sample", sample_o, 0);
    busy = 0; step();
    chk("R6 commit after busy", temp_o, 13'h1234); chk("R6 sample", sample_o, 1);
    bdone = 1; step(); bdone = 0;
    chk("R8 restart", start_o, 1);
    cdone = 1; cdata = 13'h0777; busy = 1; step(); cdone = 0; tick = 1;
    for (int i = 0; i < 10; i++) step();
    busy = 0; step(); step();
    chk("R7 discarded temp", temp_o, 13'h1234); chk("R7 no sample", sample_o, 0);
    shut = 1; step(); step();
    chk("R9 power off", pwr_o, 0); chk("R9 no start", start_o, 0);
    bdone = 1; step(); bdone = 0;
    chk("R9 bus access ignored", start_o, 0);
    cdone = 1; cdata = 13'h0042; step(); cdone = 0; step();
    chk("R9 temp held", temp_o, 13'h1234); chk("R9 no sample", sample_o, 0);
    shut = 0; step();
    chk("R2 restart after shutdown", start_o, 1);

    rst_n = 0; step(); step(); rst_n = 1;
    for (int i = 0; i < 4000; i++) begin
      step();
      chk("R3 start vs model", start_o, m_start);
      chk("R4 power vs model", pwr_o, m_pwr);
      chk("R5 temp vs model", temp_o, m_temp);
      chk("R5 valid vs model", valid_o, m_val);
      chk("R6 sample vs model", sample_o, m_sample);
      tick  = ($urandom % 2) == 0;
      if ($urandom % 200 == 0) shut = ~shut;
      if ($urandom % 12 == 0) busy = ~busy;
      bdone = ($urandom % 25) == 0;
      cdone = ($urandom % 6) == 0;
      cdata = DW'($urandom);
    end
    summary();
    $finish;
  end
endmodule